// File: doc/BRIEF.md
# External Trigger Counter Front End

This block drives a 16-bit up-counter from an external trigger pin instead of from every internal clock. The pin is asynchronous to the internal clock. It can be inverted, so that either its rising or its falling transitions qualify. It then passes through a chain of registers into the internal clock domain and through a programmable glitch filter. An edge detector follows, and after it a divide-by-1/2/4/8 prescaler. The result is a single-cycle count enable for a counter that runs entirely on the internal clock.

The control inputs look like fields of a control register. There is a polarity bit, a 2-bit prescaler code, a 4-bit filter code, an external-count-mode enable and a counter enable. The counter moves only while both enables are set. A synchronous reset clears the counter, the synchronizer, the filter and the prescaler.

Top module: `ext_trig_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` is cleared to 0. After reset with both enables clear, `count` stays 0.
- R2: With `trig_pol` = 0 a low-to-high transition of `trig_in` is a qualifying edge. With `trig_pol` = 1 a high-to-low transition qualifies and a low-to-high transition does not.
- R3: The prescaler code selects the division ratio: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8. `count` advances once for each ratio of qualifying edges.
- R4: Any change of the prescaler code restarts the prescaler, so the next advance needs a full ratio of edges under the new code.
- R5: With filter code 0, `count` changes at the fourth rising clock edge after a qualifying pin transition. With filter code N the delay is 4+N edges.
- R6: With filter code N > 0, a pin level must persist for N+1 consecutive sampled cycles before the filtered level follows. A pulse of N sampled cycles or fewer is rejected and never counted.
- R7: `count` advances only while both `ext_mode_en` and `cnt_en` are 1. Edges that arrive while either enable is 0 change neither `count` nor the prescaler phase.
- R8: `count` advances by at most 1 per clock and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous external trigger pin |
| trig_pol | input | 1 | 0: rising edges qualify; 1: falling edges qualify |
| psc_code | input | 2 | Prescaler code, ratio 2^code |
| filt_code | input | 4 | Filter length code, 0 means no filtering |
| ext_mode_en | input | 1 | External count mode enable |
| cnt_en | input | 1 | Counter enable |
| count | output | CNT_W (16) | Counter value |

## Verification
The assertions take for granted that `rst` is high for at least one clock edge before any checked cycle. They also assume that the control fields change only between clock edges, and that the filter code is not changed while the filter is partway through qualifying a new level. The bench drives every input on the falling clock edge. It changes polarity, prescaler or filter code only while the counter is disabled or the trigger has been idle long enough for the pipeline to drain. Every trigger pulse is held for whole clock periods, so the number of sampled cycles a pulse covers is known exactly.

// File: rtl/etc_pkg.sv
package etc_pkg;

  localparam int PSC_CODE_W  = 2;
  localparam int FILT_CODE_W = 4;
  // widest divide is 2**(2**PSC_CODE_W - 1), so the phase needs that many bits
  localparam int PSC_CNT_W   = (1 << PSC_CODE_W) - 1;

  typedef logic [PSC_CODE_W-1:0] psc_code_t;
  typedef logic [PSC_CNT_W-1:0]  psc_cnt_t;

  // last phase value before a count enable is issued
  function automatic psc_cnt_t psc_last(input psc_code_t code);
    psc_cnt_t one;
    one = {{(PSC_CNT_W-1){1'b0}}, 1'b1};
    return psc_cnt_t'((one << code) - one);
  endfunction

endpackage

// File: rtl/etc_sync.sv
module etc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic invert,
  output logic level
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], pin ^ invert};
  end

  assign level = chain[STAGES-1];

endmodule

// File: rtl/etc_filter.sv
module etc_filter #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  output logic              dout
);

  // number of consecutive samples seen that disagree with dout
  logic [CODE_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      run  <= '0;
    end else if (din == dout) begin
      run <= '0;
    end else if (run == code) begin
      dout <= din;
      run  <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

endmodule

// File: rtl/etc_prescale.sv
module etc_prescale
  import etc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      level,
  input  psc_code_t code,
  input  logic      gate,
  output logic      tick
);

  logic      level_d;
  psc_code_t code_d;
  psc_cnt_t  phase;
  logic      rise;
  logic      restart;

  assign rise    = level & ~level_d;
  assign restart = (code != code_d);
  assign tick    = !restart && rise && gate && (phase == psc_last(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      level_d <= 1'b0;
      code_d  <= code;
      phase   <= '0;
    end else begin
      level_d <= level;
      code_d  <= code;
      if (restart)          phase <= '0;
      else if (rise && gate) phase <= tick ? '0 : phase + 1'b1;
    end
  end

endmodule

// File: rtl/ext_trig_counter.sv
module ext_trig_counter
  import etc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   trig_in,
  input  logic                   trig_pol,
  input  logic [PSC_CODE_W-1:0]  psc_code,
  input  logic [FILT_CODE_W-1:0] filt_code,
  input  logic                   ext_mode_en,
  input  logic                   cnt_en,
  output logic [CNT_W-1:0]       count
);

  logic sync_lvl;
  logic filt_lvl;
  logic cnt_tick;

  etc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin    (trig_in),
    .invert (trig_pol),
    .level  (sync_lvl)
  );

  etc_filter #(.CODE_W(FILT_CODE_W)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .din  (sync_lvl),
    .code (filt_code),
    .dout (filt_lvl)
  );

  etc_prescale u_psc (
    .clk   (clk),
    .rst   (rst),
    .level (filt_lvl),
    .code  (psc_code),
    .gate  (ext_mode_en & cnt_en),
    .tick  (cnt_tick)
  );

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (cnt_tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/ext_trig_counter_chk.sv
module ext_trig_counter_chk #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_mode_en,
  input logic              cnt_en,
  input logic [CODE_W-1:0] filt_code,
  input logic [CNT_W-1:0]  count,
  input logic              sync_lvl,
  input logic              filt_lvl,
  input logic              cnt_tick
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R8: single step per clock, wrapping at the top
  assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + ONE));

  // R7: no movement unless both enables were set
  assert_gated_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_mode_en && cnt_en) |-> $stable(count));

  // R3: every prescaler output pulse shows up in the counter
  assert_tick_counts_R3: assert property (@(posedge clk) disable iff (rst)
    $past(cnt_tick) |-> (count != $past(count)));

  // R6: the filtered level only ever moves to the sampled level
  assert_filter_follows_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_lvl) |-> (filt_lvl == $past(sync_lvl)));

  // R5: code 0 is a plain one-register pass-through
  assert_no_filter_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(filt_code) == '0) |-> (filt_lvl == $past(sync_lvl)));

endmodule

bind ext_trig_counter ext_trig_counter_chk #(
  .CNT_W  (CNT_W),
  .CODE_W (etc_pkg::FILT_CODE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ext_mode_en (ext_mode_en),
  .cnt_en      (cnt_en),
  .filt_code   (filt_code),
  .count       (count),
  .sync_lvl    (sync_lvl),
  .filt_lvl    (filt_lvl),
  .cnt_tick    (cnt_tick)
);

// File: tb/ext_trig_counter_test.sv
`timescale 1ns/1ps
module ext_trig_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic        pol = 1'b0;
  logic [1:0]  psc = 2'd0;
  logic [3:0]  fc = 4'd0;
  logic        ext_en = 1'b0;
  logic        cen = 1'b0;
  logic [15:0] count;
  logic [3:0]  count_s;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_trig_counter uut (
    .clk(clk), .rst(rst), .trig_in(trig), .trig_pol(pol), .psc_code(psc),
    .filt_code(fc), .ext_mode_en(ext_en), .cnt_en(cen), .count(count)
  );

  ext_trig_counter #(.CNT_W(4)) uut_small (
    .clk(clk), .rst(rst), .trig_in(trig), .trig_pol(pol), .psc_code(psc),
    .filt_code(fc), .ext_mode_en(ext_en), .cnt_en(cen), .count(count_s)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: sample history, filter window, edge tally
  bit         mq[$];
  bit         mf, mfd, m_rise, m_all;
  int         m_edges;
  int         m_count;
  logic [1:0] m_prev;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      for (int i = 0; i < 20; i++) mq.push_back(1'b0);
      mf = 0; mfd = 0; m_edges = 0; m_count = 0; m_prev = psc;
    end else begin
      m_rise = mf && !mfd;
      if (psc != m_prev) m_edges = 0;
      else if (m_rise && ext_en && cen) begin
        m_edges++;
        if (m_edges == (1 << psc)) begin
          m_edges = 0;
          m_count++;
        end
      end
      mq.push_front(trig ^ pol);
      void'(mq.pop_back());
      m_all = 1;
      for (int j = 0; j <= int'(fc); j++) if (mq[2+j] == mf) m_all = 0;
      mfd = mf;
      if (m_all) mf = !mf;
      m_prev = psc;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 per-clock count vs model", int'(count), m_count & 16'hFFFF);
      chk("R8 per-clock narrow count vs model", int'(count_s), m_count & 15);
    end
  end

  task automatic pulses(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); trig = ~pol;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); trig = pol;
      repeat (lo - 1) @(negedge clk);
    end
    repeat (24) @(negedge clk);
  endtask

  task automatic quiet_config(input logic p, input logic [1:0] c, input logic [3:0] f);
    @(negedge clk);
    cen = 1'b0; pol = p; trig = p; psc = c; fc = f;
    repeat (24) @(negedge clk);
    cen = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count after reset", int'(count), 0);
    chk("R1 narrow count after reset", int'(count_s), 0);
    pulses(3, 2, 2);
    chk("R1 count stays 0 while disabled", int'(count), 0);
    ext_en = 1'b1;

    // R2 R3: every polarity and prescaler combination, 16 pulses each
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        quiet_config(p[0], c[1:0], 4'd0);
        base = count;
        pulses(16, 2, 3);
        chk($sformatf("R3 pol=%0d code=%0d count delta", p, c),
            int'(16'(count - base)), 16 >> c);
      end
    end

    // R2: falling edges qualify with pol=1, rising do not
    quiet_config(1'b1, 2'd0, 4'd0);
    base = count;
    @(negedge clk); trig = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 falling edge counted with pol=1", int'(16'(count - base)), 1);
    trig = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 rising edge ignored with pol=1", int'(16'(count - base)), 1);

    // R5: latency with filter code 0 and 2
    quiet_config(1'b0, 2'd0, 4'd0);
    base = count;
    trig = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 no change after 3 clocks, code 0", int'(16'(count - base)), 0);
    @(negedge clk);
    chk("R5 change after 4 clocks, code 0", int'(16'(count - base)), 1);
    trig = 1'b0;
    quiet_config(1'b0, 2'd0, 4'd2);
    base = count;
    trig = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 no change after 5 clocks, code 2", int'(16'(count - base)), 0);
    @(negedge clk);
    chk("R5 change after 6 clocks, code 2", int'(16'(count - base)), 1);
    trig = 1'b0;

    // R6: filter code 3 needs four samples
    quiet_config(1'b0, 2'd0, 4'd3);
    base = count;
    pulses(4, 3, 6);
    chk("R6 3-cycle glitches rejected", int'(16'(count - base)), 0);
    pulses(4, 4, 6);
    chk("R6 4-cycle pulses accepted", int'(16'(count - base)), 4);
    quiet_config(1'b1, 2'd0, 4'd3);
    base = count;
    pulses(5, 2, 6);
    chk("R6 short low glitches rejected, pol=1", int'(16'(count - base)), 0);

    // R7: disabled edges leave counter and prescaler phase alone
    quiet_config(1'b0, 2'd1, 4'd0);
    base = count;
    pulses(1, 2, 3);
    chk("R7 first of two edges, no advance", int'(16'(count - base)), 0);
    cen = 1'b0;
    pulses(3, 2, 3);
    chk("R7 edges with cnt_en=0 ignored", int'(16'(count - base)), 0);
    ext_en = 1'b0; cen = 1'b1;
    pulses(3, 2, 3);
    chk("R7 edges with ext_mode_en=0 ignored", int'(16'(count - base)), 0);
    ext_en = 1'b1;
    pulses(1, 2, 3);
    chk("R7 prescaler phase kept across disable", int'(16'(count - base)), 1);

    // R4: code change restarts the prescaler
    quiet_config(1'b0, 2'd3, 4'd0);
    base = count;
    pulses(5, 2, 3);
    chk("R4 five edges at /8, no advance", int'(16'(count - base)), 0);
    psc = 2'd1;
    repeat (3) @(negedge clk);
    pulses(2, 2, 3);
    chk("R4 two edges after switch to /2", int'(16'(count - base)), 1);

    // R8: narrow counter wraps to 0
    quiet_config(1'b0, 2'd0, 4'd0);
    for (int k = 0; k < 17 && count_s != 4'hF; k++) pulses(1, 2, 2);
    chk("R8 narrow count reached all ones", int'(count_s), 15);
    pulses(1, 2, 2);
    chk("R8 narrow count wrapped to 0", int'(count_s), 0);
    chk("R8 narrow count tracks low bits", int'(count_s), int'(count[3:0]));

    finish_run();
  end

endmodule